// File: doc/BRIEF.md
# Dual-Edge Serial Bit Counter

This block is a small wrap-around counter that counts clock events of a serial interface and raises a sticky overflow flag each time it passes from its top value back to zero. A select field chooses what it counts. The options are both edges of an external serial clock pin, a software strobe, or a tick from a companion timer. Software can load the count at any time through a write port. A one-cycle carry pulse on every wrap lets an 8-bit timer downstream extend the count to 12 bits.

Two uses follow from this. Loading the counter with all ones turns it into an edge-triggered external interrupt, because the next pin edge of either polarity wraps it and sets the flag. Counting strobes instead makes the overflow a software interrupt. The pin is brought into the system clock domain by a two-flop synchronizer. It must toggle no faster than one quarter of the system clock rate.

Top module: `serial_edge_counter`

## Requirements
- R1: After reset the count is 0, and the overflow flag, interrupt enable, interrupt request and carry output are all 0.
- R2: The source select encoding is 2'b00 none, 2'b01 external pin, 2'b10 software strobe and 2'b11 timer tick. With 2'b00 nothing increments the count.
- R3: With the pin selected, every rising edge and every falling edge of the pin adds one to the count. The new count appears after the third rising system clock edge that follows the pin change.
- R4: With the strobe selected, each cycle in which the strobe is high adds one to the count, visible after the next clock edge.
- R5: With the timer tick selected, each cycle in which the tick is high adds one to the count, visible after the next clock edge.
- R6: A counted event at count 4'hF makes the count 0 and sets the overflow flag. The flag then stays set while no clear is applied.
- R7: A flag clear pulse clears the flag after the next edge. If a wrap happens in the same cycle as the clear, the flag stays set.
- R8: A write-enable cycle loads the write data into the count after the next edge. It takes priority over an increment in the same cycle.
- R9: The interrupt enable is loaded from the enable-value input when its write strobe is high. The interrupt request is high exactly when both the flag and the enable are set.
- R10: The carry output is high for exactly one cycle, in the cycle that follows each wrap.
- R11: Inputs of sources that are not selected have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_clk | input | 1 | External serial clock pin (asynchronous) |
| sw_strobe | input | 1 | Software strobe, one count per high cycle |
| tmr_tick | input | 1 | Tick from the companion timer |
| src_sel | input | 2 | Clock source select |
| cnt_wdata | input | 4 | Count value to load |
| cnt_wr | input | 1 | Count load strobe |
| ie_wdata | input | 1 | Interrupt enable value |
| ie_wr | input | 1 | Interrupt enable load strobe |
| flag_clr | input | 1 | Write-one clear of the overflow flag |
| cnt_o | output | 4 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |
| carry_o | output | 1 | One-cycle carry pulse on wrap |

## Verification
A wrong count shows up directly on cnt_o one cycle after the bad strobe, tick or load. For pin edges it shows up three cycles after the bad edge, so every count check is placed at those fixed latencies. A corrupted flag or enable appears on ovf_flag_o and irq_o one cycle after the event that disturbed it, and a missed or doubled wrap shows up as a wrong carry_o pulse in the cycle after the wrap. The same-cycle cases are stimulated on purpose and read back on the next cycle: load against increment, clear against wrap, and a preset to all ones followed by a single pin edge.

// File: rtl/sec_pkg.sv
package sec_pkg;
    typedef enum logic [1:0] {
        SRC_OFF    = 2'b00,
        SRC_PIN    = 2'b01,
        SRC_STROBE = 2'b10,
        SRC_TIMER  = 2'b11
    } src_e;
endpackage

// File: rtl/sec_pin_sync.sv
module sec_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = st_q.chain[STAGES-1] ^ st_q.prev;
endmodule

// File: rtl/sec_src_mux.sv
module sec_src_mux
    import sec_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic       pin_edge_i,
    input  logic       strobe_i,
    input  logic       timer_i,
    output logic       tick_o
);
    always_comb begin
        unique case (src_e'(sel_i))
            SRC_PIN:    tick_o = pin_edge_i;
            SRC_STROBE: tick_o = strobe_i;
            SRC_TIMER:  tick_o = timer_i;
            default:    tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sec_count_core.sv
module sec_count_core #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             ie_wr_i,
    input  logic             ie_val_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             ie_o,
    output logic             carry_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             ie;
        logic             carry;
    } core_t;

    core_t st_d, st_q;
    logic  inc, wrap;

    always_comb begin
        inc  = tick_i && !wr_i;
        wrap = inc && (st_q.cnt == CNT_TOP);
        st_d = st_q;
        if (wr_i)     st_d.cnt = wdata_i;
        else if (inc) st_d.cnt = st_q.cnt + 1'b1;
        st_d.flag  = wrap || (st_q.flag && !clr_i);
        st_d.carry = wrap;
        if (ie_wr_i)  st_d.ie = ie_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign flag_o  = st_q.flag;
    assign ie_o    = st_q.ie;
    assign carry_o = st_q.carry;

    assert_inc_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_i) |=> $stable(cnt_o));
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wdata_i)));
    assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i && cnt_o == CNT_TOP) |=> (flag_o && cnt_o == '0));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(tick_i && !wr_i && cnt_o == CNT_TOP)) |=> !flag_o);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    assert_carry_only_after_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_o) |-> (cnt_o == '0 && flag_o));
endmodule

// File: rtl/serial_edge_counter.sv
module serial_edge_counter #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_clk,
    input  logic             sw_strobe,
    input  logic             tmr_tick,
    input  logic [1:0]       src_sel,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cnt_wr,
    input  logic             ie_wdata,
    input  logic             ie_wr,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_flag_o,
    output logic             irq_o,
    output logic             carry_o
);
    logic pin_edge, tick, ie;

    sec_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_clk), .edge_o(pin_edge)
    );

    sec_src_mux u_mux (
        .sel_i(src_sel), .pin_edge_i(pin_edge), .strobe_i(sw_strobe),
        .timer_i(tmr_tick), .tick_o(tick)
    );

    sec_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_i(cnt_wr),
        .wdata_i(cnt_wdata), .ie_wr_i(ie_wr), .ie_val_i(ie_wdata),
        .clr_i(flag_clr), .cnt_o(cnt_o), .flag_o(ovf_flag_o),
        .ie_o(ie), .carry_o(carry_o)
    );

    assign irq_o = ovf_flag_o && ie;

    assert_off_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b00 && !cnt_wr) |=> $stable(cnt_o));
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ovf_flag_o);
endmodule

// File: tb/serial_edge_counter_tb.sv
module serial_edge_counter_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_clk = 1'b0, sw_strobe = 1'b0, tmr_tick = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [3:0] cnt_wdata = '0;
    logic       cnt_wr = 1'b0, ie_wdata = 1'b0, ie_wr = 1'b0, flag_clr = 1'b0;
    logic [3:0] cnt_o;
    logic       ovf_flag_o, irq_o, carry_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        string    tag;
        logic [3:0] cnt;
        logic     flag, irq, carry;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_edge_counter u_dut (
        .clk(clk), .rst_n(rst_n), .pin_clk(pin_clk), .sw_strobe(sw_strobe),
        .tmr_tick(tmr_tick), .src_sel(src_sel), .cnt_wdata(cnt_wdata),
        .cnt_wr(cnt_wr), .ie_wdata(ie_wdata), .ie_wr(ie_wr), .flag_clr(flag_clr),
        .cnt_o(cnt_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o), .carry_o(carry_o)
    );

    task automatic expect_now(string tag, logic [3:0] c, logic f, logic i, logic k);
        exp_t e;
        e.tag = tag; e.cnt = c; e.flag = f; e.irq = i; e.carry = k;
        q.push_back(e);
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (q.size() > 0);
            #1;
            e = q.pop_front();
            n_cmp++;
            if (cnt_o !== e.cnt || ovf_flag_o !== e.flag || irq_o !== e.irq || carry_o !== e.carry) begin
                n_bad++;
                $display("FAIL %s: got cnt=%h flag=%b irq=%b carry=%b, expected cnt=%h flag=%b irq=%b carry=%b",
                         e.tag, cnt_o, ovf_flag_o, irq_o, carry_o, e.cnt, e.flag, e.irq, e.carry);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
        expect_now("R1", 4'h0, 0, 0, 0);

        // R4: three strobe cycles
        src_sel = 2'b10; sw_strobe = 1'b1;
        cycles(3);
        sw_strobe = 1'b0;
        expect_now("R4", 4'h3, 0, 0, 0);

        // R11: pin and timer activity while strobe is selected
        tmr_tick = 1'b1; pin_clk = 1'b1;
        cycles(4);
        pin_clk = 1'b0;
        cycles(4);
        tmr_tick = 1'b0;
        expect_now("R11", 4'h3, 0, 0, 0);

        // R2: source off ignores strobe and tick
        src_sel = 2'b00; sw_strobe = 1'b1; tmr_tick = 1'b1;
        cycles(2);
        sw_strobe = 1'b0; tmr_tick = 1'b0;
        expect_now("R2", 4'h3, 0, 0, 0);

        // R5: timer ticks
        src_sel = 2'b11; tmr_tick = 1'b1;
        cycles(2);
        expect_now("R5", 4'h5, 0, 0, 0);

        // R8: load beats increment in same cycle
        cnt_wr = 1'b1; cnt_wdata = 4'hE;
        cycles(1);
        cnt_wr = 1'b0;
        expect_now("R8", 4'hE, 0, 0, 0);
        cycles(1);
        expect_now("R5", 4'hF, 0, 0, 0);
        cycles(1);
        tmr_tick = 1'b0;
        expect_now("R6 R10 wrap", 4'h0, 1, 0, 1);
        cycles(1);
        expect_now("R6 R10 sticky", 4'h0, 1, 0, 0);

        // R9: enable interrupt
        ie_wr = 1'b1; ie_wdata = 1'b1;
        cycles(1);
        ie_wr = 1'b0;
        expect_now("R9", 4'h0, 1, 1, 0);

        // R7: clear
        flag_clr = 1'b1;
        cycles(1);
        flag_clr = 1'b0;
        expect_now("R7 clear", 4'h0, 0, 0, 0);

        // R7: wrap with clear in the same cycle keeps flag
        cnt_wr = 1'b1; cnt_wdata = 4'hF;
        cycles(1);
        cnt_wr = 1'b0;
        expect_now("R8", 4'hF, 0, 0, 0);
        tmr_tick = 1'b1; flag_clr = 1'b1;
        cycles(1);
        tmr_tick = 1'b0;
        expect_now("R7 collide", 4'h0, 1, 1, 1);
        cycles(1);
        flag_clr = 1'b0;
        expect_now("R7 clear2", 4'h0, 0, 0, 0);

        // R3: pin counts both edges, three-cycle latency
        src_sel = 2'b01;
        cycles(2);
        expect_now("R3 idle", 4'h0, 0, 0, 0);
        pin_clk = 1'b1;
        cycles(2);
        expect_now("R3 latency", 4'h0, 0, 0, 0);
        cycles(1);
        expect_now("R3 rise", 4'h1, 0, 0, 0);
        cycles(2);
        pin_clk = 1'b0;
        cycles(3);
        expect_now("R3 fall", 4'h2, 0, 0, 0);
        cycles(2);

        // R3 R6: preset all ones, one pin edge acts as external interrupt
        src_sel = 2'b00;
        cnt_wr = 1'b1; cnt_wdata = 4'hF;
        cycles(1);
        cnt_wr = 1'b0;
        src_sel = 2'b01;
        expect_now("R8", 4'hF, 0, 0, 0);
        pin_clk = 1'b1;
        cycles(3);
        expect_now("R3 R6 ext irq", 4'h0, 1, 1, 1);
        cycles(1);
        expect_now("R10 one pulse", 4'h0, 1, 1, 0);

        cycles(2);
        wait (q.size() == 0);
        #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule